// File: doc/BRIEF.md
# Bit-Sliced Reversible-Style Arithmetic Logic Unit

This block is a parameterised arithmetic logic unit built as a chain of identical one-bit cells. Each cell forms four candidate values at the same time from its two operand bits, an incoming carry and two mode bits. The four values are a conditioned AND term, a conditioned OR term, an add/subtract sum bit and an XOR term. A two-level selector then picks one of them. One mode bit (`mode_inv`) inverts the Y operand inside the cell. That single bit turns addition into subtraction, XOR into XNOR, and AND/OR into their one-input-inverted forms. A second mode bit (`mode_cpl`) complements the AND and OR terms.

Each cell also passes copies of its X bit and its control bits to the next cell. It exposes the candidates that were not selected on three spare outputs, so no computed value is lost. At the most significant end the chain adds a signed overflow flag and a signed less-than flag. For a subtraction, the caller drives `mode_inv=1` and `carry_in=1`. All outputs are registered once, so results appear one clock after the operands are presented.

Top module: `rev_alu_cascade`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: Every output reflects the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.
- R3: With `sel_hi=0` and `sel_lo=0`, `result` = (X AND (Y XOR {W{mode_inv}})) XOR {W{mode_cpl}}. This covers AND, NAND, X·~Y and the implication X→Y.
- R4: With `sel_hi=0` and `sel_lo=1`, `result` = (X OR (Y XOR {W{mode_inv}})) XOR {W{mode_cpl}}. This covers OR, NOR and the implication Y→X.
- R5: With `sel_hi=1` and `sel_lo=0`, `result` = low W bits of X + (Y XOR {W{mode_inv}}) + `carry_in`. `mode_cpl` has no effect.
- R6: With `sel_hi=1` and `sel_lo=1`, `result` = X XOR Y XOR {W{mode_inv}}. `mode_cpl` has no effect.
- R7: `carry_out` is bit W of X + (Y XOR {W{mode_inv}}) + `carry_in`, whatever the selector bits are.
- R8: `ovf_flag` is the carry into the top bit position XOR the carry out of it, for every control code.
- R9: `lt_flag` is bit W-1 of the arithmetic sum XOR `ovf_flag`. With `mode_inv=1` and `carry_in=1`, it is 1 exactly when X < Y as signed two's-complement numbers.
- R10: `garb_logic` is the AND/OR candidate that `sel_lo` did not pick. `garb_arith` is the sum/XOR candidate that `sel_lo` did not pick. `garb_pair` is the candidate that `sel_lo` picked from the pair that `sel_hi` rejected.
- R11: `x_echo` equals X. `ctrl_echo` equals {`mode_cpl`, `mode_inv`, `sel_hi`, `sel_lo`}, bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_x | input | W | Operand X |
| opnd_y | input | W | Operand Y |
| carry_in | input | 1 | Carry into bit 0 (1 for subtraction) |
| mode_cpl | input | 1 | Complements the AND and OR terms |
| mode_inv | input | 1 | Inverts Y; selects subtract / XNOR |
| sel_hi | input | 1 | Chooses arithmetic pair (1) or logic pair (0) |
| sel_lo | input | 1 | Chooses the second member of the pair |
| result | output | W | Selected function value |
| carry_out | output | 1 | Carry out of the top cell |
| ovf_flag | output | 1 | Signed overflow |
| lt_flag | output | 1 | Signed less-than |
| garb_logic | output | W | Unchosen AND/OR candidate |
| garb_arith | output | W | Unchosen sum/XOR candidate |
| garb_pair | output | W | Pick from the rejected pair |
| x_echo | output | W | Copy of X from the last cell chain |
| ctrl_echo | output | 4 | Control copy from the top cell |

## Verification
On every cycle after reset, the assertions check several relations. The operand and control copies must track the previous inputs. In the arithmetic codes, the carry and sum must match a plain integer addition. The overflow flag must agree with the sign pattern of the operands and the sum. The less-than flag must follow from the sum sign and the overflow, and the XOR code must produce the bitwise exclusive-or. The logic codes, the complement control, the garbage routing, the reset values and the one-cycle latency are shown only by the bench. It sweeps every control code against every 4-bit operand pair and both carry-in values, and compares each output with a model built from the requirements.

// File: rtl/ralu_pkg.sv
package ralu_pkg;

    // Control bundle carried from cell to cell
    typedef struct packed {
        logic cpl;   // complement AND/OR terms
        logic inv;   // invert Y, subtract
        logic hi;    // pair select
        logic lo;    // member select
    } ralu_ctrl_t;

    // The four candidate values one cell forms in parallel
    typedef struct packed {
        logic f_and;
        logic f_or;
        logic f_sum;
        logic f_xor;
    } ralu_terms_t;

endpackage

// File: rtl/ralu_func_gen.sv
module ralu_func_gen
    import ralu_pkg::*;
(
    input  logic        x,
    input  logic        y,
    input  logic        cin,
    input  ralu_ctrl_t  ctl,
    output ralu_terms_t terms,
    output logic        cout
);

    logic y_eff;
    logic prop;
    logic gen;

    always_comb begin
        y_eff       = y ^ ctl.inv;
        prop        = x ^ y_eff;
        gen         = x & y_eff;
        terms.f_and = gen ^ ctl.cpl;
        terms.f_or  = (x | y_eff) ^ ctl.cpl;
        terms.f_xor = prop;
        terms.f_sum = prop ^ cin;
        cout        = gen | (cin & prop);
    end

endmodule

// File: rtl/ralu_selector.sv
module ralu_selector
    import ralu_pkg::*;
(
    input  ralu_terms_t terms,
    input  logic        hi,
    input  logic        lo,
    output logic        res,
    output logic        g_logic,
    output logic        g_arith,
    output logic        g_pair
);

    logic pick_logic;
    logic pick_arith;

    always_comb begin
        // first level: member within each pair, loser kept as garbage
        pick_logic = lo ? terms.f_or  : terms.f_and;
        g_logic    = lo ? terms.f_and : terms.f_or;
        pick_arith = lo ? terms.f_xor : terms.f_sum;
        g_arith    = lo ? terms.f_sum : terms.f_xor;
        // second level: pair, loser kept as garbage
        res        = hi ? pick_arith : pick_logic;
        g_pair     = hi ? pick_logic : pick_arith;
    end

endmodule

// File: rtl/ralu_cell.sv
module ralu_cell
    import ralu_pkg::*;
(
    input  logic       x,
    input  logic       y,
    input  logic       cin,
    input  ralu_ctrl_t ctl_in,
    output ralu_ctrl_t ctl_out,
    output logic       x_copy,
    output logic       res,
    output logic       cout,
    output logic       g_logic,
    output logic       g_arith,
    output logic       g_pair
);

    ralu_terms_t terms;

    ralu_func_gen u_gen (
        .x     (x),
        .y     (y),
        .cin   (cin),
        .ctl   (ctl_in),
        .terms (terms),
        .cout  (cout)
    );

    ralu_selector u_sel (
        .terms   (terms),
        .hi      (ctl_in.hi),
        .lo      (ctl_in.lo),
        .res     (res),
        .g_logic (g_logic),
        .g_arith (g_arith),
        .g_pair  (g_pair)
    );

    assign ctl_out = ctl_in;
    assign x_copy  = x;

endmodule

// File: rtl/ralu_chain.sv
module ralu_chain
    import ralu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_x,
    input  logic [W-1:0] a_y,
    input  logic         c_in,
    input  ralu_ctrl_t   ctl,
    output logic [W-1:0] res,
    output logic [W-1:0] gl,
    output logic [W-1:0] ga,
    output logic [W-1:0] gp,
    output logic [W-1:0] xe,
    output ralu_ctrl_t   ctl_end,
    output logic         c_out,
    output logic         ovf,
    output logic         slt
);

    localparam int MSB = W - 1;

    logic [W:0] cy;
    ralu_ctrl_t link [0:W];
    logic       sum_msb;

    assign cy[0]   = c_in;
    assign link[0] = ctl;

    for (genvar i = 0; i < W; i++) begin : g_bit
        ralu_cell u_cell (
            .x       (a_x[i]),
            .y       (a_y[i]),
            .cin     (cy[i]),
            .ctl_in  (link[i]),
            .ctl_out (link[i+1]),
            .x_copy  (xe[i]),
            .res     (res[i]),
            .cout    (cy[i+1]),
            .g_logic (gl[i]),
            .g_arith (ga[i]),
            .g_pair  (gp[i])
        );
    end

    // sign-end flags, taken from the arithmetic path of the top cell
    always_comb begin
        ctl_end = link[W];
        c_out   = cy[W];
        ovf     = cy[W] ^ cy[MSB];
        sum_msb = a_x[MSB] ^ a_y[MSB] ^ link[MSB].inv ^ cy[MSB];
        slt     = sum_msb ^ ovf;
    end

endmodule

// File: rtl/rev_alu_cascade.sv
module rev_alu_cascade
    import ralu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_y,
    input  logic         carry_in,
    input  logic         mode_cpl,
    input  logic         mode_inv,
    input  logic         sel_hi,
    input  logic         sel_lo,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         ovf_flag,
    output logic         lt_flag,
    output logic [W-1:0] garb_logic,
    output logic [W-1:0] garb_arith,
    output logic [W-1:0] garb_pair,
    output logic [W-1:0] x_echo,
    output logic [3:0]   ctrl_echo
);

    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic [W-1:0] gl;
        logic [W-1:0] ga;
        logic [W-1:0] gp;
        logic [W-1:0] xe;
        logic [3:0]   ce;
        logic         co;
        logic         ov;
        logic         lt;
    } out_t;

    out_t       out_d, out_q;
    ralu_ctrl_t ctl_in, ctl_end;
    logic [W-1:0] c_res, c_gl, c_ga, c_gp, c_xe;
    logic         c_co, c_ov, c_lt;

    assign ctl_in = '{cpl: mode_cpl, inv: mode_inv, hi: sel_hi, lo: sel_lo};

    ralu_chain #(.W(W)) u_chain (
        .a_x     (opnd_x),
        .a_y     (opnd_y),
        .c_in    (carry_in),
        .ctl     (ctl_in),
        .res     (c_res),
        .gl      (c_gl),
        .ga      (c_ga),
        .gp      (c_gp),
        .xe      (c_xe),
        .ctl_end (ctl_end),
        .c_out   (c_co),
        .ovf     (c_ov),
        .slt     (c_lt)
    );

    always_comb begin
        out_d.res = c_res;
        out_d.gl  = c_gl;
        out_d.ga  = c_ga;
        out_d.gp  = c_gp;
        out_d.xe  = c_xe;
        out_d.ce  = ctl_end;
        out_d.co  = c_co;
        out_d.ov  = c_ov;
        out_d.lt  = c_lt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result     = out_q.res;
    assign garb_logic = out_q.gl;
    assign garb_arith = out_q.ga;
    assign garb_pair  = out_q.gp;
    assign x_echo     = out_q.xe;
    assign ctrl_echo  = out_q.ce;
    assign carry_out  = out_q.co;
    assign ovf_flag   = out_q.ov;
    assign lt_flag    = out_q.lt;

    // ---------------- assertions ----------------
    logic         seen_q;
    logic [W-1:0] chk_x_q, chk_y_q;
    logic [3:0]   chk_c_q;
    logic         chk_ci_q;
    logic [W:0]   chk_ref;
    logic [W-1:0] chk_yeff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            chk_x_q  <= '0;
            chk_y_q  <= '0;
            chk_c_q  <= '0;
            chk_ci_q <= 1'b0;
        end else begin
            seen_q   <= 1'b1;
            chk_x_q  <= opnd_x;
            chk_y_q  <= opnd_y;
            chk_c_q  <= {mode_cpl, mode_inv, sel_hi, sel_lo};
            chk_ci_q <= carry_in;
        end
    end

    always_comb begin
        chk_yeff = chk_y_q ^ {W{chk_c_q[2]}};
        chk_ref  = {1'b0, chk_x_q} + {1'b0, chk_yeff} + {{W{1'b0}}, chk_ci_q};
    end

    assert_echo_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (x_echo == chk_x_q && ctrl_echo == chk_c_q));

    assert_add_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && chk_c_q[1:0] == 2'b10) |-> ({carry_out, result} == chk_ref));

    assert_carry_any_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (carry_out == chk_ref[W]));

    assert_ovf_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && chk_c_q[1:0] == 2'b10) |->
        (ovf_flag == ((chk_x_q[MSB] == chk_yeff[MSB]) && (result[MSB] != chk_x_q[MSB]))));

    assert_lt_from_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && chk_c_q[1:0] == 2'b10) |-> (lt_flag == (result[MSB] ^ ovf_flag)));

    assert_xor_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && chk_c_q[1:0] == 2'b11) |-> (result == (chk_x_q ^ chk_yeff)));

endmodule

// File: tb/rev_alu_cascade_test.sv
module rev_alu_cascade_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int WATCHDOG   = 50000;

    typedef struct {
        logic [W-1:0] res, gl, ga, gp, xe;
        logic [3:0]   ce;
        logic         co, ov, lt;
        logic         is_sub;
        logic         lt_signed;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] opnd_x, opnd_y;
    logic         carry_in, mode_cpl, mode_inv, sel_hi, sel_lo;
    logic [W-1:0] result, garb_logic, garb_arith, garb_pair, x_echo;
    logic         carry_out, ovf_flag, lt_flag;
    logic [3:0]   ctrl_echo;

    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rev_alu_cascade #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .opnd_x(opnd_x), .opnd_y(opnd_y),
        .carry_in(carry_in), .mode_cpl(mode_cpl), .mode_inv(mode_inv),
        .sel_hi(sel_hi), .sel_lo(sel_lo), .result(result),
        .carry_out(carry_out), .ovf_flag(ovf_flag), .lt_flag(lt_flag),
        .garb_logic(garb_logic), .garb_arith(garb_arith), .garb_pair(garb_pair),
        .x_echo(x_echo), .ctrl_echo(ctrl_echo)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: applies one vector at the falling edge and queues its expectation
    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic ci, input logic [3:0] code);
        exp_t         e;
        logic [W-1:0] yv, f_and, f_or, f_sum, f_xor, pl, pa;
        logic [W:0]   full, low;
        logic         cmsb;
        @(negedge clk);
        opnd_x = x; opnd_y = y; carry_in = ci;
        {mode_cpl, mode_inv, sel_hi, sel_lo} = code;
        yv    = y ^ {W{code[2]}};
        full  = {1'b0, x} + {1'b0, yv} + {{W{1'b0}}, ci};
        low   = {2'b0, x[W-2:0]} + {2'b0, yv[W-2:0]} + {{W{1'b0}}, ci};
        cmsb  = low[W-1];
        f_and = (x & yv) ^ {W{code[3]}};
        f_or  = (x | yv) ^ {W{code[3]}};
        f_sum = full[W-1:0];
        f_xor = x ^ yv;
        pl    = code[0] ? f_or  : f_and;
        pa    = code[0] ? f_xor : f_sum;
        e.res = code[1] ? pa : pl;
        e.gl  = code[0] ? f_and : f_or;
        e.ga  = code[0] ? f_sum : f_xor;
        e.gp  = code[1] ? pl : pa;
        e.xe  = x;
        e.ce  = code;
        e.co  = full[W];
        e.ov  = full[W] ^ cmsb;
        e.lt  = f_sum[W-1] ^ e.ov;
        e.is_sub    = code[2] && ci;
        e.lt_signed = ($signed(x) < $signed(y));
        sb_q.push_back(e);
    endtask

    // monitor: one cycle after the vector's falling edge, just past the capturing edge (R2)
    always @(posedge clk) begin
        #1;
        if (sb_q.size() != 0) begin
            exp_t e;
            string rtag;
            e = sb_q.pop_front();
            case (e.ce[1:0])
                2'b00:   rtag = "R3 and-family";
                2'b01:   rtag = "R4 or-family";
                2'b10:   rtag = "R5 add/sub";
                default: rtag = "R6 xor/xnor";
            endcase
            check(rtag, 32'(result), 32'(e.res));
            check("R7 carry_out", 32'(carry_out), 32'(e.co));
            check("R8 ovf_flag", 32'(ovf_flag), 32'(e.ov));
            check("R9 lt_flag", 32'(lt_flag), 32'(e.lt));
            if (e.is_sub) check("R9 signed less-than", 32'(lt_flag), 32'(e.lt_signed));
            check("R10 garb_logic", 32'(garb_logic), 32'(e.gl));
            check("R10 garb_arith", 32'(garb_arith), 32'(e.ga));
            check("R10 garb_pair", 32'(garb_pair), 32'(e.gp));
            check("R11 x_echo", 32'(x_echo), 32'(e.xe));
            check("R11 ctrl_echo", 32'(ctrl_echo), 32'(e.ce));
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        opnd_x = '0; opnd_y = '0; carry_in = 1'b0;
        mode_cpl = 1'b0; mode_inv = 1'b0; sel_hi = 1'b0; sel_lo = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: all outputs cleared during reset
        check("R1 reset result", 32'(result), 32'h0);
        check("R1 reset flags", 32'({carry_out, ovf_flag, lt_flag}), 32'h0);
        check("R1 reset garbage", 32'({garb_logic, garb_arith, garb_pair}), 32'h0);
        check("R1 reset echoes", 32'({x_echo, ctrl_echo}), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: new operands do not reach the outputs before the next rising edge
        drive(4'h5, 4'h3, 1'b0, 4'b0001);
        #1;
        check("R2 latency before edge", 32'(result), 32'h0);

        // named corner cases: signed overflow on add and on subtract
        drive(4'h7, 4'h1, 1'b0, 4'b0010);
        drive(4'h8, 4'h1, 1'b1, 4'b0110);
        drive(4'h7, 4'h8, 1'b1, 4'b0110);

        // exhaustive sweep of every control code, operand pair and carry
        for (int code = 0; code < 16; code++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    for (int ci = 0; ci < 2; ci++)
                        drive(W'(x), W'(y), 1'(ci), 4'(code));

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", 32'(sb_q.size()), 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule